// File: doc/BRIEF.md
# Vector Lane Permute Unit

This block is the permute stage of a 256-bit vector execution pipeline. Each cycle in which the input strobe is high it takes one operation code, an 8-bit immediate and up to three data operands (two 256-bit sources and one 128-bit insert operand). It produces a registered 256-bit result one cycle later. Four operations share one datapath:
- a qword shuffle of one source;
- a two-source half selector with per-half zeroing;
- a half extract that clears the upper half of the result;
- a half insert that patches one half of a copy of the first source.

Alongside the operands the block receives the encoding fields that decide whether the operation is legal: a vector-length bit, a width bit and a 4-bit register-specifier field. An illegal encoding raises a one-cycle undefined-opcode flag in place of the valid flag, and the result register keeps its previous value. Decode, register file and memory operands belong to the surrounding pipeline.

The output side is a small state machine with three states. ST_IDLE means no output this cycle. ST_RESULT means the result register holds a fresh value and `res_valid` is high. ST_FAULT means the last strobe was illegal and `undef_op` is high. The state is chosen on every clock edge:
- T_ACCEPT: a strobe with a legal encoding goes to ST_RESULT.
- T_REJECT: a strobe with an illegal encoding goes to ST_FAULT.
- T_DRAIN: no strobe goes to ST_IDLE.

These three transitions apply from every state. Back-to-back strobes are therefore accepted without a gap.

Top module: `vec_lane_permute`

## Requirements
- R1: With `op_sel`=0 (qword shuffle), result qword i (bits 64i+63:64i) equals the source-A qword whose index is `imm[2i+1:2i]`. One source qword may appear in several result slots.
- R2: With `op_sel`=1 (half select), `imm[1:0]` picks the result's low 128 bits and `imm[5:4]` picks its high 128 bits. Code 0 selects A low, code 1 selects A high, code 2 selects B low and code 3 selects B high.
- R3: In half select, `imm[3]`=1 clears the low result half and `imm[7]`=1 clears the high half, whatever the selection code for that half.
- R4: With `op_sel`=2 (extract), result bits 127:0 are A low when `imm[0]`=0 and A high when `imm[0]`=1. Bits 255:128 are zero, and `imm[7:1]` have no effect.
- R5: With `op_sel`=3 (insert), the result is A with its low half replaced by `ins_data` when `imm[0]`=0, or with its high half replaced when `imm[0]`=1. `imm[7:1]` have no effect.
- R6: Any strobe with `vlen_bit`=0 is illegal, whatever the operation.
- R7: A strobe with `wide_bit`=1 is illegal for operations 1, 2 and 3. For operation 0 the width bit has no effect on the result.
- R8: An extract strobe is illegal when `spec_field` is not 4'b1111.
- R9: An illegal strobe raises `undef_op` for exactly the next cycle. In that cycle `res_valid` is low and `res_data` keeps its previous value.
- R10: After reset `res_valid`, `undef_op` and `res_data` are all zero. A legal strobe raises `res_valid` with the new `res_data` exactly one clock later, for one cycle per strobe. `res_valid` and `undef_op` are never both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operation strobe |
| op_sel | input | 2 | 0 shuffle, 1 half select, 2 extract, 3 insert |
| imm | input | 8 | Immediate control byte |
| vlen_bit | input | 1 | Vector-length encoding bit, must be 1 |
| wide_bit | input | 1 | Width encoding bit, must be 0 for ops 1 to 3 |
| spec_field | input | 4 | Register-specifier field, must be 1111b for extract |
| src_a | input | 256 | First source |
| src_b | input | 256 | Second source (half select only) |
| ins_data | input | 128 | Insert operand |
| res_valid | output | 1 | Result valid, one cycle per legal strobe |
| res_data | output | 256 | Registered result |
| undef_op | output | 1 | Undefined-opcode flag, one cycle per illegal strobe |

## Verification
The state that can go wrong here is small: the output state and the result register. A wrong state shows at the ports in the cycle after the strobe that caused it. The symptoms are a valid flag where a fault flag belongs, or either flag outliving its single cycle. Result data that moves under a fault flag, or an upper half that is not cleared after an extract, is also visible at that same cycle. The scoreboard pairs every strobe with exactly one flagged output cycle. Any extra, missing or late flag therefore shows up as an empty-queue or leftover-item failure, not as silent drift.

// File: rtl/vlp_pkg.sv
`timescale 1ns/1ps
package vlp_pkg;
    localparam int VLP_QW_W   = 64;
    localparam int VLP_N_QW   = 4;
    localparam int VLP_VEC_W  = VLP_QW_W * VLP_N_QW;
    localparam int VLP_HALF_W = VLP_VEC_W / 2;
    localparam int VLP_IDX_W  = $clog2(VLP_N_QW);
    localparam int VLP_IMM_W  = VLP_IDX_W * VLP_N_QW;
    localparam int VLP_SPEC_W = 4;

    typedef enum logic [1:0] {
        OP_SHUF = 2'd0,
        OP_HSEL = 2'd1,
        OP_EXTR = 2'd2,
        OP_INS  = 2'd3
    } vlp_op_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RESULT = 2'd1,
        ST_FAULT  = 2'd2
    } vlp_state_e;
endpackage

// File: rtl/vlp_encode_guard.sv
`timescale 1ns/1ps
module vlp_encode_guard
    import vlp_pkg::*;
#(
    parameter int SPEC_W = VLP_SPEC_W
) (
    input  vlp_op_e           op,
    input  logic              vlen_bit,
    input  logic              wide_bit,
    input  logic [SPEC_W-1:0] spec_field,
    output logic              bad
);
    logic spec_ok;
    assign spec_ok = &spec_field;

    always_comb begin
        bad = !vlen_bit;
        unique case (op)
            OP_SHUF: bad = bad;
            OP_HSEL: bad = bad | wide_bit;
            OP_EXTR: bad = bad | wide_bit | !spec_ok;
            OP_INS:  bad = bad | wide_bit;
        endcase
    end
endmodule

// File: rtl/vlp_qword_shuffle.sv
`timescale 1ns/1ps
module vlp_qword_shuffle
    import vlp_pkg::*;
#(
    parameter int QW_W = VLP_QW_W,
    parameter int N_QW = VLP_N_QW,
    localparam int VEC_W = QW_W * N_QW,
    localparam int IDX_W = $clog2(N_QW),
    localparam int IMM_W = IDX_W * N_QW
) (
    input  logic [VEC_W-1:0] src,
    input  logic [IMM_W-1:0] ctl,
    output logic [VEC_W-1:0] dst
);
    logic [QW_W-1:0] lane [N_QW];

    for (genvar s = 0; s < N_QW; s++) begin : g_unpack
        assign lane[s] = src[s*QW_W +: QW_W];
    end

    for (genvar d = 0; d < N_QW; d++) begin : g_route
        logic [IDX_W-1:0] pick;
        assign pick = ctl[d*IDX_W +: IDX_W];
        assign dst[d*QW_W +: QW_W] = lane[pick];
    end
endmodule

// File: rtl/vlp_half_route.sv
`timescale 1ns/1ps
module vlp_half_route
    import vlp_pkg::*;
#(
    parameter int HALF_W = VLP_HALF_W,
    localparam int VEC_W = 2 * HALF_W
) (
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [HALF_W-1:0] ins_data,
    input  logic [1:0]        lo_code,
    input  logic [1:0]        hi_code,
    input  logic              lo_zero,
    input  logic              hi_zero,
    input  logic              pick_hi,
    output logic [VEC_W-1:0]  sel_res,
    output logic [VEC_W-1:0]  ext_res,
    output logic [VEC_W-1:0]  ins_res
);
    logic [HALF_W-1:0] pool [4];
    logic [1:0]        code [2];
    logic              clr  [2];

    assign pool[0] = src_a[HALF_W-1:0];
    assign pool[1] = src_a[VEC_W-1:HALF_W];
    assign pool[2] = src_b[HALF_W-1:0];
    assign pool[3] = src_b[VEC_W-1:HALF_W];
    assign code[0] = lo_code;
    assign code[1] = hi_code;
    assign clr[0]  = lo_zero;
    assign clr[1]  = hi_zero;

    for (genvar h = 0; h < 2; h++) begin : g_sel
        assign sel_res[h*HALF_W +: HALF_W] = clr[h] ? '0 : pool[code[h]];
    end

    assign ext_res = {{HALF_W{1'b0}}, (pick_hi ? pool[1] : pool[0])};
    assign ins_res = pick_hi ? {ins_data, pool[0]} : {pool[1], ins_data};
endmodule

// File: rtl/vec_lane_permute.sv
`timescale 1ns/1ps
module vec_lane_permute
    import vlp_pkg::*;
#(
    parameter int QW_W   = VLP_QW_W,
    parameter int N_QW   = VLP_N_QW,
    parameter int SPEC_W = VLP_SPEC_W,
    localparam int VEC_W  = QW_W * N_QW,
    localparam int HALF_W = VEC_W / 2,
    localparam int IMM_W  = $clog2(N_QW) * N_QW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [1:0]        op_sel,
    input  logic [IMM_W-1:0]  imm,
    input  logic              vlen_bit,
    input  logic              wide_bit,
    input  logic [SPEC_W-1:0] spec_field,
    input  logic [VEC_W-1:0]  src_a,
    input  logic [VEC_W-1:0]  src_b,
    input  logic [HALF_W-1:0] ins_data,
    output logic              res_valid,
    output logic [VEC_W-1:0]  res_data,
    output logic              undef_op
);
    vlp_op_e    op;
    vlp_state_e state_q, state_d;
    logic       bad;
    logic [VEC_W-1:0] shuf_res, sel_res, ext_res, ins_res, next_data;

    assign op = vlp_op_e'(op_sel);

    vlp_encode_guard #(.SPEC_W(SPEC_W)) u_guard (
        .op         (op),
        .vlen_bit   (vlen_bit),
        .wide_bit   (wide_bit),
        .spec_field (spec_field),
        .bad        (bad)
    );

    vlp_qword_shuffle #(.QW_W(QW_W), .N_QW(N_QW)) u_shuf (
        .src (src_a),
        .ctl (imm),
        .dst (shuf_res)
    );

    vlp_half_route #(.HALF_W(HALF_W)) u_half (
        .src_a    (src_a),
        .src_b    (src_b),
        .ins_data (ins_data),
        .lo_code  (imm[1:0]),
        .hi_code  (imm[5:4]),
        .lo_zero  (imm[3]),
        .hi_zero  (imm[7]),
        .pick_hi  (imm[0]),
        .sel_res  (sel_res),
        .ext_res  (ext_res),
        .ins_res  (ins_res)
    );

    always_comb begin
        unique case (op)
            OP_SHUF: next_data = shuf_res;
            OP_HSEL: next_data = sel_res;
            OP_EXTR: next_data = ext_res;
            OP_INS:  next_data = ins_res;
        endcase
    end

    // Transitions T_ACCEPT, T_REJECT, T_DRAIN apply from every state.
    always_comb begin
        if (in_valid && !bad) begin
            state_d = ST_RESULT;
        end else if (in_valid) begin
            state_d = ST_FAULT;
        end else begin
            state_d = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_data <= '0;
        end else if (in_valid && !bad) begin
            res_data <= next_data;
        end
    end

    always_comb begin
        res_valid = 1'b0;
        undef_op  = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_RESULT: res_valid = 1'b1;
            ST_FAULT:  undef_op  = 1'b1;
            default:   ;
        endcase
    end
endmodule

// File: rtl/vlp_checker.sv
`timescale 1ns/1ps
module vlp_checker
    import vlp_pkg::*;
(
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [1:0]            op_sel,
    input logic                  vlen_bit,
    input logic                  wide_bit,
    input logic [VLP_SPEC_W-1:0] spec_field,
    input logic                  res_valid,
    input logic [VLP_VEC_W-1:0]  res_data,
    input logic                  undef_op
);
    // R6
    no_short_vlen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !vlen_bit) |=> (undef_op && !res_valid));

    // R7
    wide_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_bit && wide_bit && op_sel != 2'd0) |=> undef_op);

    // R8
    spec_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_bit && op_sel == 2'd2 && spec_field != 4'hF) |=> undef_op);

    // R9
    fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        undef_op |-> $stable(res_data));

    // R10
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({res_valid, undef_op}));

    // R10
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!res_valid && !undef_op));

    // R1
    shuf_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && vlen_bit && op_sel == 2'd0) |=> res_valid);

    // R4
    extract_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && $past(op_sel) == 2'd2) |-> (res_data[VLP_VEC_W-1:VLP_HALF_W] == '0));
endmodule

bind vec_lane_permute vlp_checker u_chk (.*);

// File: tb/vec_lane_permute_tb.sv
`timescale 1ns/1ps
module vec_lane_permute_tb;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   op_sel = '0;
    logic [7:0]   imm = '0;
    logic         vlen_bit = 1'b1;
    logic         wide_bit = 1'b0;
    logic [3:0]   spec_field = 4'hF;
    logic [255:0] src_a = '0, src_b = '0;
    logic [127:0] ins_data = '0;
    logic         res_valid, undef_op;
    logic [255:0] res_data;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic         fault;
        logic [255:0] data;
        string        tag;
    } exp_t;
    exp_t sb[$];
    logic [255:0] model_q = '0;

    always #2.5 clk = ~clk;

    vec_lane_permute u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_sel(op_sel), .imm(imm),
        .vlen_bit(vlen_bit), .wide_bit(wide_bit), .spec_field(spec_field),
        .src_a(src_a), .src_b(src_b), .ins_data(ins_data),
        .res_valid(res_valid), .res_data(res_data), .undef_op(undef_op)
    );

    function automatic logic [127:0] half_of(input logic [255:0] v, input bit hi);
        return hi ? v[255:128] : v[127:0];
    endfunction

    task automatic issue(input logic [1:0] op, input logic [7:0] im, input logic vl,
                         input logic wd, input logic [3:0] sp, input string tag);
        exp_t e;
        logic [127:0] opts [4];
        @(negedge clk);
        op_sel = op; imm = im; vlen_bit = vl; wide_bit = wd; spec_field = sp;
        in_valid = 1'b1;
        e.tag = tag;
        e.fault = !vl || (op != 2'd0 && wd) || (op == 2'd2 && sp != 4'hF);
        opts[0] = half_of(src_a, 0); opts[1] = half_of(src_a, 1);
        opts[2] = half_of(src_b, 0); opts[3] = half_of(src_b, 1);
        e.data = model_q;
        if (!e.fault) begin
            case (op)
                2'd0: for (int q = 0; q < 4; q++)
                          e.data[q*64 +: 64] = src_a[im[2*q +: 2]*64 +: 64];
                2'd1: e.data = {im[7] ? 128'd0 : opts[im[5:4]], im[3] ? 128'd0 : opts[im[1:0]]};
                2'd2: e.data = {128'd0, opts[{1'b0, im[0]}]};
                default: e.data = im[0] ? {ins_data, opts[0]} : {opts[1], ins_data};
            endcase
            model_q = e.data;
        end
        sb.push_back(e);
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    // Monitor: pops one expected item per flagged output cycle.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (rst_n && (res_valid || undef_op)) begin
                exp_t e;
                checks++;
                if (sb.size() == 0) begin
                    errors++;
                    $display("FAIL R10 unexpected output valid=%0b undef=%0b expected none",
                             res_valid, undef_op);
                end else begin
                    e = sb.pop_front();
                    if (undef_op !== e.fault || res_valid !== !e.fault || res_data !== e.data) begin
                        errors++;
                        $display("FAIL %s valid=%0b undef=%0b data=%h expected undef=%0b data=%h",
                                 e.tag, res_valid, undef_op, res_data, e.fault, e.data);
                    end
                end
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        src_a = {64'hA3A3_0000_0000_0003, 64'hA2A2_0000_0000_0002,
                 64'hA1A1_0000_0000_0001, 64'hA0A0_0000_0000_0000};
        src_b = {64'hB3B3_1111_2222_3333, 64'hB2B2_4444_5555_6666,
                 64'hB1B1_7777_8888_9999, 64'hB0B0_AAAA_BBBB_CCCC};
        ins_data = {64'h1D1D_DEAD_BEEF_0001, 64'h1D1D_CAFE_F00D_0000};
        repeat (3) @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || undef_op !== 1'b0 || res_data !== '0) begin
            errors++;
            $display("FAIL R10 reset valid=%0b undef=%0b data=%h expected 0 0 0",
                     res_valid, undef_op, res_data);
        end
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (res_valid !== 1'b0 || undef_op !== 1'b0) begin
            errors++;
            $display("FAIL R10 idle after reset valid=%0b undef=%0b expected 0 0", res_valid, undef_op);
        end

        issue(2'd0, 8'h1B, 1, 0, 4'h0, "R1 reverse"); idle();
        issue(2'd0, 8'h00, 1, 0, 4'h0, "R1 broadcast"); idle();
        issue(2'd0, 8'hE4, 1, 1, 4'h0, "R7 shuffle ignores width"); idle();
        issue(2'd1, 8'h31, 1, 0, 4'hF, "R2 A-high/B-high"); idle();
        issue(2'd1, 8'h20, 1, 0, 4'hF, "R2 A-low/B-low"); idle();
        issue(2'd1, 8'h3A, 1, 0, 4'hF, "R3 low zero"); idle();
        issue(2'd1, 8'h88, 1, 0, 4'hF, "R3 both zero"); idle();
        issue(2'd2, 8'hFE, 1, 0, 4'hF, "R4 extract low, upper imm ignored"); idle();
        issue(2'd2, 8'h01, 1, 0, 4'hF, "R4 extract high"); idle();
        issue(2'd3, 8'h00, 1, 0, 4'h3, "R5 insert low"); idle();
        issue(2'd3, 8'hFF, 1, 0, 4'h3, "R5 insert high"); idle();
        issue(2'd0, 8'h1B, 0, 0, 4'hF, "R6 R9 shuffle short vlen"); idle();
        issue(2'd3, 8'h01, 0, 0, 4'hF, "R6 R9 insert short vlen"); idle();
        issue(2'd1, 8'h20, 1, 1, 4'hF, "R7 R9 half select wide"); idle();
        issue(2'd2, 8'h01, 1, 1, 4'hF, "R7 extract wide"); idle();
        issue(2'd3, 8'h00, 1, 1, 4'hF, "R7 insert wide"); idle();
        issue(2'd2, 8'h01, 1, 0, 4'hE, "R8 extract bad spec"); idle();
        issue(2'd1, 8'h13, 1, 0, 4'hF, "R10 burst first");
        issue(2'd2, 8'h00, 1, 0, 4'h7, "R10 R8 burst fault");
        issue(2'd0, 8'h4E, 1, 0, 4'h0, "R10 burst third"); idle();
        repeat (4) @(negedge clk);

        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10 missing outputs left=%0d expected 0", sb.size());
        end
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule